// File: doc/BRIEF.md
# SD Command Line Issue Unit

This block drives a single SD/MMC command onto the CMD line and collects the card's reply. Register logic loads a 32-bit argument and then writes an 11-bit control word. When the enable bit of that word is set, the unit builds a 48-bit frame and shifts it out one bit per SD clock strobe (`sd_tick`). If the control word asks for a reply, the unit waits a bounded number of strobes for a start bit. It then shifts in a 48-bit or 136-bit reply, checks the framing and CRC7, and stores the payload in four 32-bit response words plus an echo register. The outcome is reported through sticky status flags. Clock generation, the data lines and the bus interface sit outside this block.

The controller is one state machine with six states:
- `S_IDLE` waits for a control write. A write with the reset bit set moves to `S_RESET`. A write with the enable bit set moves to `S_SEND`.
- `S_RESET` holds for `RST_CYCLES` clocks and then returns to `S_IDLE`.
- `S_SEND` shifts the 48 frame bits out. After the last bit it moves to `S_WAIT` if a reply is needed, and otherwise back to `S_IDLE` with the sent flag set.
- `S_WAIT` watches for a low start bit. It moves to `S_RECV` when one arrives, or to `S_IDLE` with the timeout flag set when the wait window ends.
- `S_RECV` shifts the reply bits in and moves to `S_CHECK` on the last bit.
- `S_CHECK` judges the reply in one cycle and returns to `S_IDLE`.

Top module: `sdc_cmd_issuer`

## Requirements
- R1: Control word fields: bits 5:0 are the command index, bit 6 requests a reply, bit 7 selects a 136-bit reply, bit 8 marks an application command, bit 9 starts the command and bit 10 requests a controller reset. A control write in idle with bit 9 set (and bit 10 clear) starts a command using the argument loaded earlier through `arg_wr`.
- R2: The frame is 48 bits sent MSB first, one bit per `sd_tick`, with `cmd_oe` high for exactly those 48 bits. The bits are, in order: start 0, transmission 1, index, argument, CRC7 over the first 40 bits (polynomial x^7+x^3+1, zero seed), and end bit 1. While idle, `cmd_out` rests at 1.
- R3: When no reply is requested, status bit 6 (sent) is set in the same clock edge that ends the last frame bit, and `busy` falls.
- R4: A short reply of 48 bits is accepted when it carries a 00 header, a CRC7 over its bits 47:8 that matches bits 7:1, and an end bit of 1. An accepted reply sets status bit 4, places bits 39:8 in `rsp_word0` and leaves words 1 to 3 unchanged. It also sets `rsp_echo` to {app flag, reply bits 45:40}.
- R5: A reply whose CRC7 does not match sets status bit 0 and leaves all response words and `rsp_echo` unchanged.
- R6: A long reply of 136 bits is checked with CRC7 over its bits 127:8. When accepted, `rsp_word0` holds bits 127:96, and words 1, 2 and 3 hold the next lower 32-bit slices down to bit 0. `rsp_echo` becomes {app flag, reply bits 133:128}.
- R7: After the frame, the line is sampled at each tick. A low level on any of the first `RSP_WAIT` (64) ticks is taken as the start bit, including the 64th tick. If no start bit arrives within those ticks, status bit 2 is set and `busy` falls on the 64th tick.
- R8: Status bits stay set until `clr_wr` pulses with a 1 in that bit position of `clr_wdata`. A clear pulse for other bit positions leaves them set.
- R9: After `rst_n`, the status, response words and echo are zero, `busy` is 0 and `cmd_oe` is 0. A control write in idle with bit 10 set raises `reset_pending` and zeroes the status on the next clock. `reset_pending` drops by itself after `RST_CYCLES` clocks, by which time the response words and echo are also zero.
- R10: While `busy` is high, control writes are ignored: no reset starts and the running command completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_tick | input | 1 | One-cycle strobe per SD clock bit time |
| arg_wr | input | 1 | Load strobe for the argument |
| arg_wdata | input | 32 | Command argument |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 11 | Control word |
| clr_wr | input | 1 | Status clear strobe |
| clr_wdata | input | 7 | Write-one-to-clear mask |
| cmd_in | input | 1 | CMD line level from the card |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command or reset in progress |
| reset_pending | output | 1 | Reset bit readback, clears itself |
| status | output | 7 | Sticky flags: 0 CRC fail, 2 timeout, 4 reply ok, 6 sent |
| rsp_word0 | output | 32 | Response word 0 |
| rsp_word1 | output | 32 | Response word 1 |
| rsp_word2 | output | 32 | Response word 2 |
| rsp_word3 | output | 32 | Response word 3 |
| rsp_echo | output | 7 | {app flag, received index} |

## Verification
The hardest point to reach from the ports is the edge of the reply window: the start bit arriving on the very last tick that still counts, as opposed to the tick after it. The bench acts as a card that follows the tick strobe. For each vector it holds the line high for a chosen number of ticks before driving the start bit. One vector uses a delay of 63 ticks, so the start bit lands on the 64th tick. The timeout vector instead checks that `busy` is still high after 63 ticks and low after the 64th. Corrupted CRCs on both reply lengths check that the stored words survive a failed reply.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RESET,
        S_SEND,
        S_WAIT,
        S_RECV,
        S_CHECK
    } sdc_state_e;

    // control word bit positions
    localparam int CW_NEED = 6;
    localparam int CW_LONG = 7;
    localparam int CW_APP  = 8;
    localparam int CW_EN   = 9;
    localparam int CW_RST  = 10;
    localparam int CW_W    = 11;

    // status bit positions
    localparam int ST_FAIL = 0;
    localparam int ST_TMO  = 2;
    localparam int ST_OK   = 4;
    localparam int ST_SENT = 6;
    localparam int ST_W    = 7;

    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
    parameter int W = 40
) (
    input  logic [W-1:0] din,
    output logic [6:0]   crc
);
    logic [6:0] acc;
    logic       fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            fb  = din[i] ^ acc[6];
            acc = {acc[5:0], 1'b0};
            if (fb) acc = acc ^ 7'h09;
        end
        crc = acc;
    end
endmodule

// File: rtl/sdc_flags.sv
module sdc_flags #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flags <= '0;
        else if (wipe) flags <= '0;
        else           flags <= (flags & ~clr_eff) | set_vec;
    end

    // R8: a set flag survives unless its own clear bit was written
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe |=> ((($past(flags) & ~$past(clr_eff)) & ~flags) == '0));
endmodule

// File: rtl/sdc_cmd_issuer.sv
module sdc_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int RSP_WAIT   = 64,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sd_tick,
    input  logic        arg_wr,
    input  logic [31:0] arg_wdata,
    input  logic        ctl_wr,
    input  logic [10:0] ctl_wdata,
    input  logic        clr_wr,
    input  logic [6:0]  clr_wdata,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic        busy,
    output logic        reset_pending,
    output logic [6:0]  status,
    output logic [31:0] rsp_word0,
    output logic [31:0] rsp_word1,
    output logic [31:0] rsp_word2,
    output logic [31:0] rsp_word3,
    output logic [6:0]  rsp_echo
);
    localparam int WAIT_W = $clog2(RSP_WAIT + 1);
    localparam int RSTC_W = $clog2(RST_CYCLES + 1);
    localparam int CNT_W  = $clog2(LONG_BITS + 1);

    sdc_state_e state_q, state_d;

    logic [31:0]            arg_q;
    logic [5:0]             idx_q;
    logic                   need_q, long_q, app_q;
    logic [SHORT_BITS-1:0]  tx_sr;
    logic [LONG_BITS-1:0]   rx_sr;
    logic [CNT_W-1:0]       bit_cnt;
    logic [WAIT_W-1:0]      wait_cnt;
    logic [RSTC_W-1:0]      rst_cnt;
    logic [6:0]             crc_tx, crc_s, crc_l;
    logic                   start_cmd, start_rst, last_tx, wait_exp, last_rx, crc_good;
    logic [ST_W-1:0]        set_vec;

    sdc_crc7 #(.W(40))  u_crc_tx (.din({2'b01, ctl_wdata[5:0], arg_q}), .crc(crc_tx));
    sdc_crc7 #(.W(40))  u_crc_s  (.din(rx_sr[47:8]),   .crc(crc_s));
    sdc_crc7 #(.W(120)) u_crc_l  (.din(rx_sr[127:8]),  .crc(crc_l));

    // event decode
    always_comb begin
        start_rst = ctl_wr && (state_q == S_IDLE) && ctl_wdata[CW_RST];
        start_cmd = ctl_wr && (state_q == S_IDLE) && ctl_wdata[CW_EN] && !ctl_wdata[CW_RST];
        last_tx   = (state_q == S_SEND) && sd_tick && (bit_cnt == CNT_W'(SHORT_BITS - 1));
        wait_exp  = (state_q == S_WAIT) && sd_tick && cmd_in
                    && (wait_cnt == WAIT_W'(RSP_WAIT - 1));
        last_rx   = (state_q == S_RECV) && sd_tick
                    && (bit_cnt == (long_q ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1)));
        crc_good  = long_q ? (rx_sr[135:134] == 2'b00 && crc_l == rx_sr[7:1] && rx_sr[0])
                           : (rx_sr[47:46] == 2'b00 && crc_s == rx_sr[7:1] && rx_sr[0]);
        set_vec          = '0;
        set_vec[ST_SENT] = last_tx && !need_q;
        set_vec[ST_TMO]  = wait_exp;
        set_vec[ST_OK]   = (state_q == S_CHECK) && crc_good;
        set_vec[ST_FAIL] = (state_q == S_CHECK) && !crc_good;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_rst) state_d = S_RESET;
                     else if (start_cmd) state_d = S_SEND;
            S_RESET: if (rst_cnt == RSTC_W'(RST_CYCLES - 1)) state_d = S_IDLE;
            S_SEND:  if (last_tx) state_d = need_q ? S_WAIT : S_IDLE;
            S_WAIT:  if (sd_tick && !cmd_in) state_d = S_RECV;
                     else if (wait_exp) state_d = S_IDLE;
            S_RECV:  if (last_rx) state_d = S_CHECK;
            S_CHECK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cmd_oe        = (state_q == S_SEND);
        cmd_out       = (state_q == S_SEND) ? tx_sr[SHORT_BITS-1] : 1'b1;
        busy          = (state_q != S_IDLE);
        reset_pending = (state_q == S_RESET);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0; idx_q <= '0; need_q <= 1'b0; long_q <= 1'b0; app_q <= 1'b0;
            tx_sr <= '0; rx_sr <= '0; bit_cnt <= '0; wait_cnt <= '0; rst_cnt <= '0;
            rsp_word0 <= '0; rsp_word1 <= '0; rsp_word2 <= '0; rsp_word3 <= '0;
            rsp_echo <= '0;
        end else begin
            if (arg_wr) arg_q <= arg_wdata;
            unique case (state_q)
                S_IDLE: begin
                    rst_cnt <= '0;
                    if (start_cmd) begin
                        idx_q   <= ctl_wdata[5:0];
                        need_q  <= ctl_wdata[CW_NEED];
                        long_q  <= ctl_wdata[CW_LONG];
                        app_q   <= ctl_wdata[CW_APP];
                        tx_sr   <= {2'b01, ctl_wdata[5:0], arg_q, crc_tx, 1'b1};
                        bit_cnt <= '0;
                    end
                end
                S_RESET: begin
                    rst_cnt   <= rst_cnt + 1'b1;
                    rsp_word0 <= '0; rsp_word1 <= '0; rsp_word2 <= '0; rsp_word3 <= '0;
                    rsp_echo  <= '0;
                end
                S_SEND: if (sd_tick) begin
                    tx_sr    <= {tx_sr[SHORT_BITS-2:0], 1'b1};
                    bit_cnt  <= last_tx ? '0 : bit_cnt + 1'b1;
                    wait_cnt <= '0;
                end
                S_WAIT: if (sd_tick) begin
                    if (!cmd_in) begin
                        rx_sr   <= {rx_sr[LONG_BITS-2:0], cmd_in};
                        bit_cnt <= CNT_W'(1);
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                S_RECV: if (sd_tick) begin
                    rx_sr   <= {rx_sr[LONG_BITS-2:0], cmd_in};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                S_CHECK: if (crc_good) begin
                    if (long_q) begin
                        rsp_word0 <= rx_sr[127:96];
                        rsp_word1 <= rx_sr[95:64];
                        rsp_word2 <= rx_sr[63:32];
                        rsp_word3 <= rx_sr[31:0];
                        rsp_echo  <= {app_q, rx_sr[133:128]};
                    end else begin
                        rsp_word0 <= rx_sr[39:8];
                        rsp_echo  <= {app_q, rx_sr[45:40]};
                    end
                end
                default: ;
            endcase
        end
    end

    sdc_flags #(.W(ST_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .wipe(start_rst),
        .clr_en(clr_wr), .clr_mask(clr_wdata),
        .set_vec(set_vec), .flags(status)
    );

    // R2: frame opens with a start bit of 0 and closes with an end bit of 1
    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
    p_end_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_tx |-> cmd_out);
    // R7: wait counter never passes the window
    p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |-> (wait_cnt < WAIT_W'(RSP_WAIT)));
    // R4: at most one outcome flag per command end
    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_vec[ST_OK], set_vec[ST_FAIL], set_vec[ST_TMO], set_vec[ST_SENT]}));
    // R10: a reset request while busy does not start a reset
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reset_pending && ctl_wr && ctl_wdata[CW_RST]) |=> !reset_pending);
    // R9: reset phase is bounded
    p_reset_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pending |-> (rst_cnt < RSTC_W'(RST_CYCLES)));
endmodule

// File: tb/sdc_cmd_issuer_test.sv
module sdc_cmd_issuer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_tick = 1'b0;
    logic        arg_wr = 1'b0;
    logic [31:0] arg_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [10:0] ctl_wdata = '0;
    logic        clr_wr = 1'b0;
    logic [6:0]  clr_wdata = '0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, busy, reset_pending;
    logic [6:0]  status, rsp_echo;
    logic [31:0] rsp_word0, rsp_word1, rsp_word2, rsp_word3;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    sdc_cmd_issuer uut (
        .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .busy(busy), .reset_pending(reset_pending), .status(status),
        .rsp_word0(rsp_word0), .rsp_word1(rsp_word1),
        .rsp_word2(rsp_word2), .rsp_word3(rsp_word3), .rsp_echo(rsp_echo)
    );

    always #2.5 clk = ~clk;

    initial begin : tick_gen
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            sd_tick = (tc % 4 == 0);
        end
    end

    // mode[92:90] ctl[89:79] arg[78:47] seed[46:15] dly[14:7] exp_status[6:0]
    // mode: 0 none, 1 short ok, 2 short bad crc, 3 long ok, 4 silent card, 5 long bad crc
    localparam int NV = 7;
    localparam logic [92:0] VECS [NV] = '{
        {3'd0, 11'h200, 32'h0000_0000, 32'h0000_0000, 8'd0,  7'h40},
        {3'd1, 11'h251, 32'h0000_1234, 32'h0000_0900, 8'd2,  7'h10},
        {3'd2, 11'h34D, 32'hFFFF_0000, 32'h1234_5678, 8'd5,  7'h01},
        {3'd3, 11'h2C2, 32'h0000_0000, 32'hCAFE_F00D, 8'd1,  7'h10},
        {3'd4, 11'h248, 32'h0000_01AA, 32'h0000_0000, 8'd0,  7'h04},
        {3'd1, 11'h369, 32'h40FF_8000, 32'h80FF_8000, 8'd63, 7'h10},
        {3'd5, 11'h2C9, 32'h0001_0000, 32'h0BAD_BEEF, 8'd3,  7'h01}
    };

    // remainder of d * x^7 divided by x^7+x^3+1, low n bits of d significant
    function automatic logic [6:0] crc_div(input logic [119:0] d, input int n);
        logic [7:0] r;
        r = '0;
        for (int i = n + 6; i >= 0; i--) begin
            r = {r[6:0], (i >= 7) ? d[i-7] : 1'b0};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!sd_tick) @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        while (busy) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_arg(input logic [31:0] v);
        arg_wdata = v; arg_wr = 1'b1;
        @(posedge clk); #1 arg_wr = 1'b0;
    endtask

    task automatic write_ctl(input logic [10:0] v);
        ctl_wdata = v; ctl_wr = 1'b1;
        @(posedge clk); #1 ctl_wr = 1'b0;
    endtask

    task automatic write_clr(input logic [6:0] v);
        clr_wdata = v; clr_wr = 1'b1;
        @(posedge clk); #1 clr_wr = 1'b0;
    endtask

    task automatic capture_frame(output logic [47:0] f, output logic oe_ok);
        oe_ok = 1'b1;
        for (int k = 0; k < 48; k++) begin
            f[47-k] = cmd_out;
            if (!cmd_oe) oe_ok = 1'b0;
            wait_tick();
        end
        if (cmd_oe) oe_ok = 1'b0;
    endtask

    task automatic drive_reply(input logic [135:0] bits, input int n, input int dly);
        cmd_in = 1'b1;
        for (int d = 0; d < dly; d++) wait_tick();
        for (int k = n - 1; k >= 0; k--) begin
            cmd_in = bits[k];
            wait_tick();
        end
        cmd_in = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ew [4];
        logic [6:0]  eecho;
        logic [47:0] frm, efrm;
        logic        oe_ok;
        logic [135:0] reply;
        logic [119:0] content;
        logic [6:0]  c;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R9: state after reset
        chk("R9 status after rst", 64'(status), 64'h0);
        chk("R9 busy after rst", 64'(busy), 64'h0);
        chk("R9 oe after rst", 64'(cmd_oe), 64'h0);
        chk("R2 idle line level", 64'(cmd_out), 64'h1);
        chk("R9 words after rst", {rsp_word0, rsp_word3}, 64'h0);
        chk("R9 echo after rst", 64'(rsp_echo), 64'h0);
        for (int i = 0; i < 4; i++) ew[i] = '0;
        eecho = '0;

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  mode;
            logic [10:0] ctl;
            logic [31:0] arg, seed;
            int          dly;
            logic [6:0]  exp_st;
            mode = VECS[v][92:90]; ctl = VECS[v][89:79]; arg = VECS[v][78:47];
            seed = VECS[v][46:15]; dly = int'(VECS[v][14:7]); exp_st = VECS[v][6:0];

            write_arg(arg);
            write_ctl(ctl);
            // R1: enable bit starts the command
            chk("R1 busy after enable write", 64'(busy), 64'h1);
            capture_frame(frm, oe_ok);
            efrm = {2'b01, ctl[5:0], arg, crc_div(120'({2'b01, ctl[5:0], arg}), 40), 1'b1};
            chk("R2 frame bits", 64'(frm), 64'(efrm));
            chk("R2 oe window", 64'(oe_ok), 64'h1);

            if (mode == 3'd0) begin
                chk("R3 busy drops after frame", 64'(busy), 64'h0);
            end else if (mode == 3'd4) begin
                for (int t = 0; t < 63; t++) wait_tick();
                chk("R7 still waiting after 63 ticks", 64'(busy), 64'h1);
                wait_tick();
                chk("R7 timeout on 64th tick", 64'(busy), 64'h0);
            end else if (mode == 3'd1 || mode == 3'd2) begin
                c = crc_div(120'({2'b00, ctl[5:0], seed}), 40);
                if (mode == 3'd2) c = c ^ 7'h01;
                reply = 136'({2'b00, ctl[5:0], seed, c, 1'b1});
                drive_reply(reply, 48, dly);
                wait_idle();
                if (mode == 3'd1) begin
                    ew[0] = seed;
                    eecho = {ctl[8], ctl[5:0]};
                end
            end else begin
                content = {seed, seed ^ 32'hA5A5_A5A5, ~seed, seed[23:0]};
                c = crc_div(content, 120);
                if (mode == 3'd5) c = c ^ 7'h40;
                reply = {8'h3F, content, c, 1'b1};
                drive_reply(reply, 136, dly);
                wait_idle();
                if (mode == 3'd3) begin
                    ew[0] = reply[127:96]; ew[1] = reply[95:64];
                    ew[2] = reply[63:32];  ew[3] = reply[31:0];
                    eecho = {ctl[8], 6'h3F};
                end
            end

            // R3 R4 R5 R6 R7: outcome flag
            chk($sformatf("R4 R5 R6 status vector %0d", v), 64'(status), 64'(exp_st));
            chk($sformatf("R4 R6 word0 vector %0d", v), 64'(rsp_word0), 64'(ew[0]));
            chk($sformatf("R6 word1 vector %0d", v), 64'(rsp_word1), 64'(ew[1]));
            chk($sformatf("R6 word2 vector %0d", v), 64'(rsp_word2), 64'(ew[2]));
            chk($sformatf("R5 R6 word3 vector %0d", v), 64'(rsp_word3), 64'(ew[3]));
            chk($sformatf("R4 echo vector %0d", v), 64'(rsp_echo), 64'(eecho));

            // R8: sticky until own bit is cleared
            repeat (5) @(posedge clk);
            #1;
            chk("R8 flag holds", 64'(status), 64'(exp_st));
            write_clr(~exp_st);
            chk("R8 other-bit clear ignored", 64'(status), 64'(exp_st));
            write_clr(exp_st);
            chk("R8 own-bit clear", 64'(status), 64'h0);
        end

        // R10: control writes during a command are ignored
        write_arg(32'h0000_0000);
        write_ctl(11'h200);
        wait_tick(); wait_tick(); wait_tick();
        write_ctl(11'h400);
        chk("R10 reset ignored while busy", 64'(reset_pending), 64'h0);
        write_ctl(11'h251);
        wait_idle();
        chk("R10 original command completes", 64'(status), 64'h40);
        chk("R10 no reply wait started", 64'(rsp_echo), 64'(eecho));

        // R9: controller reset clears itself
        write_ctl(11'h400);
        chk("R9 reset bit reads back", 64'(reset_pending), 64'h1);
        chk("R9 status wiped", 64'(status), 64'h0);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset still pending", 64'(reset_pending), 64'h1);
        @(posedge clk); #1;
        chk("R9 reset self-clears", 64'(reset_pending), 64'h0);
        chk("R9 words wiped", {rsp_word0, rsp_word1}, 64'h0);
        chk("R9 words2 wiped", {rsp_word2, rsp_word3}, 64'h0);
        chk("R9 echo wiped", 64'(rsp_echo), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule